// File: doc/BRIEF.md
# Coded-Mark-Inversion Line Decoder with Violation Flag

This block turns a coded-mark-inversion (CMI) line stream back into NRZ data. Bit alignment and sampling happen upstream: each incoming beat carries `LANES` bit periods. Each bit period arrives as a pair of half-bit samples: the sample from the first half in `in_first` and the sample from the second half in `in_second`. Lane 0 is the earliest bit in time. For every bit the block produces the decoded NRZ value. It also produces a flag that marks a bit breaking either coding rule: the shape of a zero, or the alternation of levels between successive ones.

Both data streams use valid/ready handshakes. The input beat is taken on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or is being drained in the same cycle. A beat shown with `out_valid` high stays unchanged until `out_ready` is seen high. The mode select `cmi_en` and the line-loss input `los` are plain control pins, sampled together with each accepted beat. With `cmi_en` low the block passes NRZ data through. With `los` high, every bit of the beat is squelched.

Top module: `cmi_rx_decode`

## Requirements
- R1: In CMI mode without loss, a lane whose samples are first low then high decodes to 0 with the flag low.
- R2: In CMI mode without loss, a lane whose two samples are equal decodes to 1. Its level is the sample value.
- R3: In CMI mode without loss, a lane whose samples are first high then low decodes to 0 with the flag high.
- R4: A one whose level equals the level of the most recent earlier one is flagged. This holds across lanes and across beats. The remembered level always follows the level actually received, so a single bad one is flagged once.
- R5: After reset, after a beat taken in NRZ mode, and after a beat taken during loss, no level is remembered. The next one is not flagged.
- R6: With `cmi_en` low, each output data bit equals the lane's `in_first` sample and every flag bit is 0.
- R7: For a beat accepted while `los` is high, all data and flag bits are 0, in either mode.
- R8: An accepted beat appears on `out_data` and `out_lcv` together with `out_valid`, one clock after acceptance.
- R9: While `out_valid` is high and `out_ready` is low, `in_ready` is low and the outputs hold steady.
- R10: Active-low asynchronous reset empties the output register and clears the remembered level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmi_en | input | 1 | 1 = CMI decoding, 0 = NRZ pass-through |
| los | input | 1 | Loss of signal, squelches the accepted beat |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Input beat accepted this cycle when high |
| in_first | input | LANES | First half-bit sample per lane (NRZ bit in NRZ mode) |
| in_second | input | LANES | Second half-bit sample per lane |
| out_valid | output | 1 | Output beat present |
| out_ready | input | 1 | Downstream takes the output beat |
| out_data | output | LANES | Decoded NRZ bits, lane 0 earliest |
| out_lcv | output | LANES | Per-bit code-violation flag |

## Verification
Squelch on loss and violation detection can fall in the same beat. The bench provokes this by presenting malformed zeros and repeated-level ones while `los` is high, and expects all zeros on both output buses. The following clean beat must then carry no flag on its first one, because loss cleared the remembered level. A second overlap is a back-pressure stall in the same cycle as a new beat that would move the level tracker. That beat must neither be accepted nor disturb the held output.

// File: rtl/cmi_rx_pkg.sv
package cmi_rx_pkg;
  typedef enum logic [1:0] {
    SYM_ZERO   = 2'd0,
    SYM_ONE_LO = 2'd1,
    SYM_ONE_HI = 2'd2,
    SYM_BADZ   = 2'd3
  } cmi_sym_e;
endpackage

// File: rtl/cmi_pair_classify.sv
module cmi_pair_classify
  import cmi_rx_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic [LANES-1:0]      first_i,
  input  logic [LANES-1:0]      second_i,
  output logic [LANES-1:0][1:0] sym_o
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_comb begin
      unique case ({first_i[g], second_i[g]})
        2'b01:   sym_o[g] = SYM_ZERO;
        2'b00:   sym_o[g] = SYM_ONE_LO;
        2'b11:   sym_o[g] = SYM_ONE_HI;
        default: sym_o[g] = SYM_BADZ;
      endcase
    end
  end
endmodule

// File: rtl/cmi_level_track.sv
module cmi_level_track
  import cmi_rx_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  advance_i,
  input  logic                  clear_i,
  input  logic [LANES-1:0][1:0] sym_i,
  output logic [LANES-1:0]      viol_o
);
  logic ref_valid_q, ref_lvl_q;
  logic ref_valid_d, ref_lvl_d;

  always_comb begin
    logic v, l;
    v = ref_valid_q;
    l = ref_lvl_q;
    for (int i = 0; i < LANES; i++) begin
      viol_o[i] = 1'b0;
      unique case (cmi_sym_e'(sym_i[i]))
        SYM_ONE_LO: begin viol_o[i] = v && !l; v = 1'b1; l = 1'b0; end
        SYM_ONE_HI: begin viol_o[i] = v &&  l; v = 1'b1; l = 1'b1; end
        SYM_BADZ:   viol_o[i] = 1'b1;
        default:    viol_o[i] = 1'b0;
      endcase
    end
    ref_valid_d = v;
    ref_lvl_d   = l;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_valid_q <= 1'b0;
      ref_lvl_q   <= 1'b0;
    end else if (advance_i) begin
      if (clear_i) begin
        ref_valid_q <= 1'b0;
        ref_lvl_q   <= 1'b0;
      end else begin
        ref_valid_q <= ref_valid_d;
        ref_lvl_q   <= ref_lvl_d;
      end
    end
  end
endmodule

// File: rtl/cmi_out_stage.sv
module cmi_out_stage #(
  parameter int LANES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid_i,
  output logic             in_ready_o,
  input  logic [LANES-1:0] data_i,
  input  logic [LANES-1:0] lcv_i,
  output logic             out_valid_o,
  input  logic             out_ready_i,
  output logic [LANES-1:0] data_o,
  output logic [LANES-1:0] lcv_o
);
  assign in_ready_o = !out_valid_o || out_ready_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid_o <= 1'b0;
      data_o      <= '0;
      lcv_o       <= '0;
    end else if (in_ready_o) begin
      out_valid_o <= in_valid_i;
      if (in_valid_i) begin
        data_o <= data_i;
        lcv_o  <= lcv_i;
      end
    end
  end
endmodule

// File: rtl/cmi_rx_decode.sv
module cmi_rx_decode
  import cmi_rx_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmi_en,
  input  logic             los,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [LANES-1:0] in_first,
  input  logic [LANES-1:0] in_second,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [LANES-1:0] out_data,
  output logic [LANES-1:0] out_lcv
);
  logic [LANES-1:0][1:0] sym;
  logic [LANES-1:0]      viol;
  logic [LANES-1:0]      cmi_bits;
  logic [LANES-1:0]      data_d, lcv_d;
  logic                  accept;

  assign accept = in_valid && in_ready;

  cmi_pair_classify #(.LANES(LANES)) cls_i (
    .first_i (in_first),
    .second_i(in_second),
    .sym_o   (sym)
  );

  cmi_level_track #(.LANES(LANES)) trk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .advance_i(accept),
    .clear_i  (!cmi_en || los),
    .sym_i    (sym),
    .viol_o   (viol)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_bit
    assign cmi_bits[g] = (cmi_sym_e'(sym[g]) == SYM_ONE_LO) ||
                         (cmi_sym_e'(sym[g]) == SYM_ONE_HI);
  end

  always_comb begin
    if (los) begin
      data_d = '0;
      lcv_d  = '0;
    end else if (cmi_en) begin
      data_d = cmi_bits;
      lcv_d  = viol;
    end else begin
      data_d = in_first;
      lcv_d  = '0;
    end
  end

  cmi_out_stage #(.LANES(LANES)) out_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid_i (in_valid),
    .in_ready_o (in_ready),
    .data_i     (data_d),
    .lcv_i      (lcv_d),
    .out_valid_o(out_valid),
    .out_ready_i(out_ready),
    .data_o     (out_data),
    .lcv_o      (out_lcv)
  );
endmodule

// File: rtl/cmi_rx_decode_chk.sv
module cmi_rx_decode_chk #(
  parameter int LANES = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmi_en,
  input logic             los,
  input logic             in_valid,
  input logic             in_ready,
  input logic [LANES-1:0] in_first,
  input logic [LANES-1:0] in_second,
  input logic             out_valid,
  input logic             out_ready,
  input logic [LANES-1:0] out_data,
  input logic [LANES-1:0] out_lcv
);
  logic acc;
  assign acc = in_valid && in_ready;

  AST_ZERO_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    acc && cmi_en && !los && !in_first[0] && in_second[0] |=> !out_data[0] && !out_lcv[0]); // R1
  AST_ONE_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    acc && cmi_en && !los && (in_first[0] == in_second[0]) |=> out_data[0]); // R2
  AST_BADZ_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    acc && cmi_en && !los && in_first[0] && !in_second[0] |=> out_lcv[0] && !out_data[0]); // R3
  AST_NRZ_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    acc && !cmi_en && !los |=> (out_data == $past(in_first)) && (out_lcv == '0)); // R6
  AST_LOS_SQUELCH: assert property (@(posedge clk) disable iff (!rst_n)
    acc && los |=> (out_data == '0) && (out_lcv == '0)); // R7
  AST_VALID_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> out_valid); // R8
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_lcv)); // R9
  AST_STALL_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready); // R9
endmodule

bind cmi_rx_decode cmi_rx_decode_chk #(.LANES(LANES)) chk_i (
  .clk(clk), .rst_n(rst_n), .cmi_en(cmi_en), .los(los),
  .in_valid(in_valid), .in_ready(in_ready), .in_first(in_first),
  .in_second(in_second), .out_valid(out_valid), .out_ready(out_ready),
  .out_data(out_data), .out_lcv(out_lcv)
);

// File: tb/cmi_rx_decode_tb_top.sv
module cmi_rx_decode_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int LANES = 4;
  localparam int NVEC = 8;
  // {cmi_en, los, first[3:0], second[3:0], exp_data[3:0], exp_lcv[3:0]}, lane 0 = bit 0
  localparam logic [17:0] VEC [NVEC] = '{
    18'b1_0_0100_0101_1110_0000, // R1 R2 R5: zero, first one unflagged, alternating ones
    18'b1_0_0110_1010_0011_0101, // R3 R4: repeated low across beats, bad zero
    18'b1_0_0011_1011_0111_0011, // R4: repeated high twice, flagged each time
    18'b0_0_1001_0110_1001_0000, // R6: NRZ pass-through
    18'b1_0_0001_1111_0001_0000, // R5: no reference after NRZ beat
    18'b1_1_0011_1110_0000_0000, // R7: loss squelches a bad zero and a repeat
    18'b1_0_1001_1001_1111_0100, // R5 R4: reference cleared by loss
    18'b0_1_1111_0000_0000_0000  // R7: loss wins in NRZ mode
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmi_en = 1'b1, los = 1'b0, in_valid = 1'b0, out_ready = 1'b1;
  logic [LANES-1:0] in_first = '0, in_second = '0;
  logic in_ready, out_valid;
  logic [LANES-1:0] out_data, out_lcv;
  int checks = 0, errors = 0, cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cmi_rx_decode #(.LANES(LANES)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmi_en(cmi_en), .los(los),
    .in_valid(in_valid), .in_ready(in_ready), .in_first(in_first),
    .in_second(in_second), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_lcv(out_lcv)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000) begin
      errors++;
      $display("FAIL watchdog actual %0d expected <= 5000 cycles", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R10 out_valid in reset", {7'd0, out_valid}, 8'd0);
    chk("R10 in_ready in reset", {7'd0, in_ready}, 8'd1);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NVEC; i++) begin
      cmi_en = VEC[i][17]; los = VEC[i][16];
      in_first = VEC[i][15:12]; in_second = VEC[i][11:8];
      in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      chk($sformatf("R8 valid vec%0d", i), {7'd0, out_valid}, 8'd1);
      chk($sformatf("R1/R2/R6/R7 data vec%0d", i), {4'd0, out_data}, {4'd0, VEC[i][7:4]});
      chk($sformatf("R3/R4/R5 lcv vec%0d", i), {4'd0, out_lcv}, {4'd0, VEC[i][3:0]});
      @(negedge clk);
    end

    // R9: stall with a new beat waiting
    cmi_en = 1'b1; los = 1'b0; out_ready = 1'b0;
    in_first = 4'b0000; in_second = 4'b0000; in_valid = 1'b1; // all low ones
    @(negedge clk);
    in_first = 4'b1111; in_second = 4'b0000;                   // all bad zeros
    chk("R9 in_ready low while stalled", {7'd0, in_ready}, 8'd0);
    chk("R9 first beat lcv", {4'd0, out_lcv}, 8'h0E);
    @(negedge clk);
    chk("R9 data held", {4'd0, out_data}, 8'h0F);
    chk("R9 lcv held", {4'd0, out_lcv}, 8'h0E);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R9 second beat data", {4'd0, out_data}, 8'h00);
    chk("R3 second beat lcv", {4'd0, out_lcv}, 8'h0F);
    @(negedge clk);

    // R10: reset clears the remembered level (last one was low)
    rst_n = 1'b0;
    @(negedge clk);
    chk("R10 out_valid after reset", {7'd0, out_valid}, 8'd0);
    rst_n = 1'b1;
    @(negedge clk);
    in_first = 4'b0000; in_second = 4'b0000; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R10 data after reset", {4'd0, out_data}, 8'h0F);
    chk("R10 lcv after reset", {4'd0, out_lcv}, 8'h0E);
    @(negedge clk);
    chk("R8 valid drops when idle", {7'd0, out_valid}, 8'd0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule